// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Legacy Status Flags

This block takes two operands, an operation code, a carry/borrow input and a byte/word width select. In the cycle after a request it returns the arithmetic or logic result together with a 16-bit status word. The status word holds six condition flags at fixed bit positions. The control bits of an incoming status word (single-step, interrupt enable, string direction and the upper nibble) are copied into the outgoing word unchanged. This allows the block to sit in a datapath that updates the condition flags and leaves the control state alone.

Seven operations are supported: plain and carry-chained addition, plain and borrow-chained subtraction, and bitwise AND, OR and XOR. In byte mode, only the low half of each operand takes part. The carry, sign and overflow flags are then taken at the byte boundary, and the upper half of the result is zero. The result and the status word are held in an output register stage that loads only when a request is presented.

Top module: `alu_flag_unit`

## Requirements
- R1: When `in_valid` is 1 at a rising clock edge, `out_valid` is 1 after that edge and `result`/`flags_out` carry the answer for that request. When `in_valid` is 0, `out_valid` falls to 0 and `result`/`flags_out` keep their previous values.
- R2: The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 XOR. When `wide` is 0, only operand bits 7:0 are used and result bits 15:8 are 0. When `wide` is 1, all 16 bits are used. Results are truncated to the selected width.
- R3: Status bit 0 (carry) is 1 when an addition carries out of the selected width, or when a subtraction needs a borrow into it.
- R4: Status bit 2 (parity) is 1 when result bits 7:0 hold an even number of ones, for both widths.
- R5: Status bit 4 (half carry) is 1 when an addition carries from bit 3 into bit 4, or when a subtraction borrows across that boundary.
- R6: Status bit 6 (zero) is 1 exactly when the result is zero.
- R7: Status bit 7 (sign) equals the top bit of the selected width: result bit 15 in word mode and bit 7 in byte mode.
- R8: Status bit 11 (overflow) is 1 when the signed result does not fit in the selected width.
- R9: For codes 4 to 7, status bits 0, 4 and 11 are 0, and `cin` has no effect.
- R10: Status bits 8, 9, 10 and 15:12 are copied from `flags_in`. Bit 1 is always 1, and bits 3 and 5 are always 0.
- R11: While `rst_n` is 0, `out_valid` is 0, `result` is 0 and `flags_out` is 16'h0002.
- R12: Codes 0 and 2 ignore `cin`. Codes 1 and 3 add `cin` as a carry or subtract it as a borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the output stage |
| op | input | 3 | Operation code |
| wide | input | 1 | 1 = 16-bit word, 0 = 8-bit byte |
| a | input | DATA_W | First operand |
| b | input | DATA_W | Second operand (subtrahend) |
| cin | input | 1 | Carry or borrow input for the chained codes |
| flags_in | input | 16 | Incoming status word supplying the control bits |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | DATA_W | Registered result |
| flags_out | output | 16 | Registered status word |

## Verification
Half carry, signed overflow and carry derive from separate carry taps of one adder, and a single result can raise all three along with sign and zero. Operand pairs such as 16'h7FFF plus 1, 16'h8000 minus 1, and their byte-mode equivalents, drive several of these flags in the same cycle. A scoreboard built from plain integer arithmetic then checks the whole status word. Back-to-back requests with changing widths check that the byte-mode and word-mode taps never mix between adjacent cycles.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int STAT_W = 16;

  localparam int POS_CARRY  = 0;
  localparam int POS_ONE    = 1;
  localparam int POS_PAR    = 2;
  localparam int POS_RSV3   = 3;
  localparam int POS_HALF   = 4;
  localparam int POS_RSV5   = 5;
  localparam int POS_ZERO   = 6;
  localparam int POS_SIGN   = 7;
  localparam int POS_OVF    = 11;

  // Bits copied from the incoming status word: 15:12 and 10:8
  localparam logic [STAT_W-1:0] KEEP_MASK = 16'hF700;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_ADC  = 3'd1,
    OPC_SUB  = 3'd2,
    OPC_SBB  = 3'd3,
    OPC_AND  = 3'd4,
    OPC_OR   = 3'd5,
    OPC_XOR  = 3'd6,
    OPC_XORA = 3'd7
  } opc_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              do_sub,
  input  logic              chain_in,
  input  logic              wide,
  output logic [DATA_W-1:0] sum,
  output logic              carry_top,
  output logic              carry_msb,
  output logic              carry_nib
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NIB    = 4;

  logic [DATA_W-1:0] b_eff;
  logic              c0;
  logic [DATA_W:0]   ext;
  logic [DATA_W:0]   cv;
  logic              unused_cv_fold;

  always_comb begin
    b_eff = do_sub ? ~op_b : op_b;
    c0    = do_sub ? ~chain_in : chain_in;
    ext   = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c0};
    // carry into each bit position, recovered from the sum
    cv    = {1'b0, op_a} ^ {1'b0, b_eff} ^ ext;
    sum   = ext[DATA_W-1:0];
    carry_top = wide ? cv[DATA_W]   : cv[HALF_W];
    carry_msb = wide ? cv[DATA_W-1] : cv[HALF_W-1];
    carry_nib = cv[NIB];
  end

  assign unused_cv_fold = ^cv;

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (sel)
      2'd0:    res = op_a & op_b;
      2'd1:    res = op_a | op_b;
      default: res = op_a ^ op_b;
    endcase
  end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] res,
  input  logic              wide,
  input  logic              is_logic,
  input  logic              cy,
  input  logic              hc,
  input  logic              ov,
  input  logic [STAT_W-1:0] ctl_in,
  output logic [STAT_W-1:0] word
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAR_W  = 8;

  logic unused_ctl_fold;

  always_comb begin
    word             = ctl_in & KEEP_MASK;
    word[POS_CARRY]  = is_logic ? 1'b0 : cy;
    word[POS_ONE]    = 1'b1;
    word[POS_PAR]    = ~^res[PAR_W-1:0];
    word[POS_RSV3]   = 1'b0;
    word[POS_HALF]   = is_logic ? 1'b0 : hc;
    word[POS_RSV5]   = 1'b0;
    word[POS_ZERO]   = (res == '0);
    word[POS_SIGN]   = wide ? res[DATA_W-1] : res[HALF_W-1];
    word[POS_OVF]    = is_logic ? 1'b0 : ov;
  end

  assign unused_ctl_fold = ^(ctl_in & ~KEEP_MASK);

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic [15:0]       flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [15:0]       flags_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [STAT_W-1:0] RST_WORD = 16'h0002;

  logic              is_logic, is_sub, chain_en;
  logic [DATA_W-1:0] as_sum, lg_res, raw, res_n;
  logic              c_top, c_msb, c_nib;
  logic              ar_cy, ar_hc, ar_ov;
  logic [STAT_W-1:0] word_n;

  logic              vld_d;
  logic [DATA_W-1:0] res_d;
  logic [STAT_W-1:0] flg_d;

  always_comb begin
    is_logic = op[2];
    is_sub   = (op[2:1] == 2'b01);
    chain_en = ~op[2] & op[0];
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op_a      (a),
    .op_b      (b),
    .do_sub    (is_sub),
    .chain_in  (chain_en & cin),
    .wide      (wide),
    .sum       (as_sum),
    .carry_top (c_top),
    .carry_msb (c_msb),
    .carry_nib (c_nib)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_a (a),
    .op_b (b),
    .sel  (op[1:0]),
    .res  (lg_res)
  );

  always_comb begin
    raw   = is_logic ? lg_res : as_sum;
    res_n = wide ? raw : {{(DATA_W-HALF_W){1'b0}}, raw[HALF_W-1:0]};
    // subtraction runs as a + ~b + ~borrow: invert carry taps into borrows
    ar_cy = c_top ^ is_sub;
    ar_hc = c_nib ^ is_sub;
    ar_ov = c_top ^ c_msb;
  end

  alu_flag_pack #(.DATA_W(DATA_W)) u_pack (
    .res      (res_n),
    .wide     (wide),
    .is_logic (is_logic),
    .cy       (ar_cy),
    .hc       (ar_hc),
    .ov       (ar_ov),
    .ctl_in   (flags_in),
    .word     (word_n)
  );

  always_comb begin
    vld_d = in_valid;
    res_d = result;
    flg_d = flags_out;
    if (in_valid) begin
      res_d = res_n;
      flg_d = word_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= RST_WORD;
    end else begin
      out_valid <= vld_d;
      result    <= res_d;
      flags_out <= flg_d;
    end
  end

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              wide,
  input logic [15:0]       flags_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [15:0]       flags_out
);
  localparam int HALF_W = DATA_W / 2;

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R1
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags_out)));

  // R10
  a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[1] && !flags_out[3] && !flags_out[5]);

  // R10
  a_r10_ctl_copy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[10:8] == $past(flags_in[10:8]) &&
                   flags_out[15:12] == $past(flags_in[15:12])));

  // R6
  a_r6_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[6] == (result == '0)));

  // R7
  a_r7_sign_tap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[7] == ($past(wide) ? result[DATA_W-1] : result[HALF_W-1])));

  // R2
  a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(wide)) |-> (result[DATA_W-1:HALF_W] == '0));

  // R9
  a_r9_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op[2])) |-> (!flags_out[0] && !flags_out[4] && !flags_out[11]));

  // R4
  a_r4_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[2] == ($countones(result[7:0]) % 2 == 0)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .wide      (wide),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out)
);

// File: tb/tb_alu_flag_unit.sv
`timescale 1ns/1ps
module tb_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic        wide;
  logic [15:0] a, b;
  logic        cin;
  logic [15:0] flags_in;
  logic        out_valid;
  logic [15:0] result;
  logic [15:0] flags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [15:0] res;
    logic [15:0] flg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] last_res = 16'h0000;
  logic [15:0] last_flg = 16'h0002;

  always #4 clk = ~clk;

  alu_flag_unit #(.DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .a(a), .b(b), .cin(cin), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .flags_out(flags_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference built from integer arithmetic on the requirements
  function automatic logic [31:0] model(input logic [2:0] o, input logic w,
                                        input logic [15:0] x, input logic [15:0] y,
                                        input logic ci, input logic [15:0] fi);
    int mask, av, bv, c, full, top;
    logic [15:0] aa, bb, r, f;
    logic cf, af, of;
    mask = w ? 32'hFFFF : 32'hFF;
    top  = w ? 15 : 7;
    av = int'(x) & mask;
    bv = int'(y) & mask;
    aa = av[15:0];
    bb = bv[15:0];
    c  = (o == 3'd1 || o == 3'd3) ? int'(ci) : 0;
    cf = 0; af = 0; of = 0;
    if (o == 3'd0 || o == 3'd1) begin
      full = av + bv + c;
      r  = 16'(full & mask);
      cf = full > mask;
      af = ((av & 15) + (bv & 15) + c) > 15;
      of = (aa[top] == bb[top]) && (r[top] != aa[top]);
    end else if (o == 3'd2 || o == 3'd3) begin
      full = av - bv - c;
      r  = 16'(full & mask);
      cf = full < 0;
      af = ((av & 15) - (bv & 15) - c) < 0;
      of = (aa[top] != bb[top]) && (r[top] != aa[top]);
    end else if (o == 3'd4) r = aa & bb;
    else if (o == 3'd5)     r = aa | bb;
    else                    r = aa ^ bb;
    f = fi & 16'hF700;
    f[0]  = cf;
    f[1]  = 1'b1;
    f[2]  = ~^r[7:0];
    f[4]  = af;
    f[6]  = (r == 16'h0);
    f[7]  = r[top];
    f[11] = of;
    return {f, r};
  endfunction

  // Driver: call right after a falling edge
  task automatic apply(input string tag, input logic [2:0] o, input logic w,
                       input logic [15:0] x, input logic [15:0] y,
                       input logic ci, input logic [15:0] fi);
    logic [31:0] m;
    exp_t e;
    op = o; wide = w; a = x; b = y; cin = ci; flags_in = fi; in_valid = 1'b1;
    m = model(o, w, x, y, ci, fi);
    e.res = m[15:0]; e.flg = m[31:16]; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    a = 16'hDEAD; b = 16'hBEEF; op = 3'd3; cin = 1'b1; flags_in = 16'hFFFF;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scoreboard compare on the falling edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (sb.size() == 0) begin
        check(0, "R1 unexpected out_valid", {31'd0, out_valid}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(result === e.res,    {e.tag, " result"}, {16'd0, result},    {16'd0, e.res});
        check(flags_out === e.flg, {e.tag, " flags"},  {16'd0, flags_out}, {16'd0, e.flg});
        last_res = e.res;
        last_flg = e.flg;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; op = 3'd0; wide = 1'b1;
    a = 16'h1111; b = 16'h2222; cin = 1'b0; flags_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R11: reset state, even with a request present
    check(out_valid === 1'b0,    "R11 out_valid", {31'd0, out_valid}, 32'd0);
    check(result === 16'h0,      "R11 result",    {16'd0, result},    32'd0);
    check(flags_out === 16'h0002,"R11 flags",     {16'd0, flags_out}, 32'h2);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R6: word add wrapping to zero, carry out
    apply("R3 word add carry",   3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, 16'h0000);
    apply("R2 adc word",         3'd1, 1'b1, 16'h1234, 16'h1111, 1'b1, 16'h0000);
    apply("R3 word sub borrow",  3'd2, 1'b1, 16'h0000, 16'h0001, 1'b0, 16'h0000);
    apply("R2 sbb word",         3'd3, 1'b1, 16'h0005, 16'h0003, 1'b1, 16'h0000);
    apply("R3 byte add carry",   3'd0, 1'b0, 16'h12FF, 16'h3401, 1'b0, 16'h0000);
    apply("R3 byte sub borrow",  3'd2, 1'b0, 16'hFF10, 16'h0020, 1'b0, 16'h0000);
    // R12: cin ignored on plain codes
    apply("R12 add ignores cin", 3'd0, 1'b1, 16'h0010, 16'h0020, 1'b1, 16'h0000);
    apply("R12 sub ignores cin", 3'd2, 1'b0, 16'h0030, 16'h0010, 1'b1, 16'h0000);
    apply("R12 sbb byte borrow", 3'd3, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000);
    // R8/R5/R7: overflow, half carry and sign in the same result
    apply("R8 word pos ovf",     3'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0, 16'h0000);
    apply("R8 byte pos ovf",     3'd0, 1'b0, 16'h007F, 16'h0001, 1'b0, 16'h0000);
    apply("R8 word neg ovf",     3'd2, 1'b1, 16'h8000, 16'h0001, 1'b0, 16'h0000);
    apply("R8 byte neg ovf",     3'd2, 1'b0, 16'h0080, 16'h0001, 1'b0, 16'h0000);
    apply("R5 half carry add",   3'd0, 1'b0, 16'h000F, 16'h0001, 1'b0, 16'h0000);
    apply("R5 half borrow sub",  3'd2, 1'b1, 16'h0010, 16'h0001, 1'b0, 16'h0000);
    apply("R7 byte sign",        3'd0, 1'b0, 16'h0040, 16'h0040, 1'b0, 16'h0000);
    // R4: parity on low byte only
    apply("R4 even parity",      3'd5, 1'b1, 16'h0003, 16'h0000, 1'b0, 16'h0000);
    apply("R4 odd parity",       3'd5, 1'b1, 16'h0007, 16'h0000, 1'b0, 16'h0000);
    apply("R4 word low byte 0",  3'd5, 1'b1, 16'h0100, 16'h0000, 1'b0, 16'h0000);
    // R9: logic ops clear arithmetic flags, cin ignored
    apply("R9 and",              3'd4, 1'b1, 16'hF0F0, 16'hFF00, 1'b1, 16'h0801);
    apply("R9 or",               3'd5, 1'b0, 16'h8081, 16'h0102, 1'b1, 16'h0811);
    apply("R9 xor",              3'd6, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000);
    apply("R9 xor alt code",     3'd7, 1'b0, 16'h00A5, 16'h005A, 1'b1, 16'hFFFF);
    // R10: control bits copied, reserved bits fixed
    apply("R10 ctl all ones",    3'd0, 1'b1, 16'h0001, 16'h0001, 1'b0, 16'hFFFF);
    apply("R10 ctl pattern",     3'd2, 1'b1, 16'h0005, 16'h0001, 1'b0, 16'hA5AA);

    // R1: hold when idle
    idle(3);
    check(out_valid === 1'b0,   "R1 idle valid",  {31'd0, out_valid}, 32'd0);
    check(result === last_res,  "R1 idle result", {16'd0, result},    {16'd0, last_res});
    check(flags_out === last_flg,"R1 idle flags", {16'd0, flags_out}, {16'd0, last_flg});

    // Random back-to-back traffic with gaps and width changes
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      apply("R2 random", ro, 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom),
            1'($urandom_range(0, 1)), 16'($urandom));
      if (i % 37 == 0) idle(2);
    end
    idle(3);
    check(sb.size() == 0, "R1 all results returned", sb.size(), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule